// File: doc/BRIEF.md
# Dual-Select Byte-Masked Static RAM Model

A synthesizable, scaled-down model of an asynchronous low-power static RAM with 16-bit words on a shared bidirectional data bus. It has two chip selects (one active low, one active high), an active-low output enable, an active-low write enable, and separate active-low enables for the upper and lower byte lanes. Each byte lane goes to high impedance independently. It is intended as a checkable target for memory-controller testbenches and as a loopback memory inside an FPGA.

The device is selected when `sel_n` is low and `sel` is high. The array is read asynchronously. Reads drive only the enabled byte lanes. A write is open while the device is selected, `we_n` is low and at least one byte enable is low. Every rising clock edge inside that window samples the address, the bus and the lane mask. The word is committed on the first clock edge at which the window has closed, and only the enabled bytes are written. The window closes when `we_n` rises, when either select drops, or when both byte enables go high. Optional checks report write pulses shorter than `MIN_WP` clock samples and address changes during a write.

Top module: `lp_sram_model`

## Requirements
- R1: With the device selected, `we_n` low and both byte enables low, the whole 16-bit word from `dq` is stored. The value of `oe_n` during the write has no effect.
- R2: A write with only `ub_n` low updates bits 15:8 (the upper lane) and keeps bits 7:0. A write with only `lb_n` low updates bits 7:0 and keeps bits 15:8.
- R3: With the device selected, `we_n` high and `oe_n` low, the stored upper byte is driven on `dq[15:8]` when `ub_n` is low, and the lower byte on `dq[7:0]` when `lb_n` is low. Each disabled lane floats.
- R4: While selected, both lanes float if `oe_n` and `we_n` are both high, or if `ub_n` and `lb_n` are both high. A write attempt with both byte enables high changes no stored byte.
- R5: When `sel_n` is high or `sel` is low, both lanes float, and a write attempt changes nothing.
- R6: The lanes are released combinationally. They float within the same clock period in which the select drops, with no clock edge in between.
- R7: While `we_n` is low the block never drives `dq`. A write ended by raising `we_n`, by `sel_n` going high, by `sel` going low, or by raising both byte enables stores the address, data and lanes sampled on the last clock edge of the write.
- R8: Reset discards a write that is in progress. Reset does not clear the stored contents.
- R9: A write held for exactly `MIN_WP` clock samples at a stable address is stored. The checker flags shorter write pulses and address changes inside a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the write window |
| rst_n | input | 1 | Asynchronous active-low reset of the pending write |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| ub_n | input | 1 | Active-low upper byte (bits 15:8) enable |
| lb_n | input | 1 | Active-low lower byte (bits 7:0) enable |
| dq | inout | 16 | Shared bidirectional data bus |

## Verification
A stale pending-write flag or a wrong latched lane mask corrupts one byte lane. That shows at the ports on the first read of the address after the write. A write lost at the closing edge shows the same way. A lane-enable decode error shows at once as a lane that is driven when it should float, or that floats when it should be driven. The bench samples such reads in the same clock period as the control change. The bench ends writes in each of the four possible ways and uses reset during a write to expose the commit timing.

// File: rtl/lp_sram_model.sv
`timescale 1ns/1ps
module lp_sram_model #(
  parameter int ADDR_W = 8,
  parameter int MIN_WP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  inout  wire  [15:0]       dq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0]       mem [DEPTH];
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;
  logic [1:0]        mask_q;

  wire chip_on = !sel_n && sel;
  wire wr_act  = chip_on && !we_n && !(ub_n && lb_n);
  wire rd_act  = chip_on && we_n && !oe_n;
  wire drv_hi  = rd_act && !ub_n;
  wire drv_lo  = rd_act && !lb_n;
  wire commit  = wr_q && !wr_act;
  wire [15:0] rd_word = mem[addr];

  assign dq[15:8] = drv_hi ? rd_word[15:8] : 8'hzz;
  assign dq[7:0]  = drv_lo ? rd_word[7:0]  : 8'hzz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_act;

  always_ff @(posedge clk)
    if (wr_act) begin
      addr_q <= addr;
      data_q <= dq;
      mask_q <= {!ub_n, !lb_n};
    end

  always_ff @(posedge clk)
    if (commit) begin
      if (mask_q[1]) mem[addr_q][15:8] <= data_q[15:8];
      if (mask_q[0]) mem[addr_q][7:0]  <= data_q[7:0];
    end
endmodule

// File: rtl/lp_sram_model_chk.sv
`timescale 1ns/1ps
module lp_sram_model_chk #(
  parameter int ADDR_W = 8,
  parameter int MIN_WP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              oe_n,
  input logic              we_n,
  input logic              ub_n,
  input logic              lb_n,
  input logic              chip_on,
  input logic              wr_act,
  input logic              drv_hi,
  input logic              drv_lo,
  input logic              wr_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [15:0]       data_q,
  input logic [1:0]        mask_q,
  input logic [15:0]       mem [1 << ADDR_W]
);
  logic [7:0] wp_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       wp_cnt <= '0;
    else if (!wr_act)                 wp_cnt <= '0;
    else if (wp_cnt != 8'hff)         wp_cnt <= wp_cnt + 8'd1;

  p_deselect_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_on |-> (!drv_hi && !drv_lo));

  p_idle_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && ((oe_n && we_n) || (ub_n && lb_n))) |-> (!drv_hi && !drv_lo));

  p_no_drive_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!drv_hi && !drv_lo));

  p_commit_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_act && mask_q[1]) |=> (mem[$past(addr_q)][15:8] == $past(data_q[15:8])));

  p_commit_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_act && mask_q[0]) |=> (mem[$past(addr_q)][7:0] == $past(data_q[7:0])));

  p_keep_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_act && !mask_q[1]) |=> (mem[$past(addr_q)][15:8] == $past(mem[addr_q][15:8])));

  p_keep_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_act && !mask_q[0]) |=> (mem[$past(addr_q)][7:0] == $past(mem[addr_q][7:0])));

  p_min_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_act) |-> (wp_cnt >= 8'(MIN_WP)));

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_q) |-> (addr == addr_q));
endmodule

bind lp_sram_model lp_sram_model_chk #(.ADDR_W(ADDR_W), .MIN_WP(MIN_WP)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .oe_n(oe_n), .we_n(we_n),
  .ub_n(ub_n), .lb_n(lb_n), .chip_on(chip_on), .wr_act(wr_act),
  .drv_hi(drv_hi), .drv_lo(drv_lo), .wr_q(wr_q), .addr_q(addr_q),
  .data_q(data_q), .mask_q(mask_q), .mem(mem)
);

// File: tb/lp_sram_model_tb_top.sv
`timescale 1ns/1ps
module lp_sram_model_tb_top;
  localparam int AW = 8;
  localparam int WP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic tb_oe = 1'b0;
  logic [15:0] tb_dq = '0;
  tri1 [15:0] dq;
  assign dq = tb_oe ? tb_dq : 16'hzzzz;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] ref_mem [1 << AW];
  bit ref_vh [1 << AW];
  bit ref_vl [1 << AW];

  always #10 clk = ~clk;

  lp_sram_model #(.ADDR_W(AW), .MIN_WP(WP)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
    .oe_n(oe_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .dq(dq));

  function automatic logic [7:0] exp_lane(bit drive, logic [7:0] stored);
    return drive ? stored : 8'hff;
  endfunction

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; sel = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    ub_n = 1'b1; lb_n = 1'b1; tb_oe = 1'b0;
  endtask

  // mode: 0 we_n rises, 1 sel_n rises, 2 sel falls, 3 both byte enables rise
  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, bit u_n, bit l_n,
                          bit o_n, bit cs_n, bit cs, int hold, int mode);
    @(negedge clk);
    addr = a; sel_n = cs_n; sel = cs; oe_n = o_n; ub_n = u_n; lb_n = l_n;
    we_n = 1'b0; tb_dq = d; tb_oe = 1'b1;
    repeat (hold) @(negedge clk);
    case (mode)
      1: sel_n = 1'b1;
      2: sel = 1'b0;
      3: begin ub_n = 1'b1; lb_n = 1'b1; end
      default: we_n = 1'b1;
    endcase
    tb_oe = 1'b0;
    @(negedge clk);
    idle();
    if (!cs_n && cs) begin
      if (!u_n) begin ref_mem[a][15:8] = d[15:8]; ref_vh[a] = 1'b1; end
      if (!l_n) begin ref_mem[a][7:0] = d[7:0]; ref_vl[a] = 1'b1; end
    end
  endtask

  task automatic do_read(string tag, logic [AW-1:0] a, bit u_n, bit l_n,
                         bit o_n, bit cs_n, bit cs);
    bit rd;
    @(negedge clk);
    addr = a; sel_n = cs_n; sel = cs; oe_n = o_n; ub_n = u_n; lb_n = l_n; we_n = 1'b1;
    #2;
    rd = !cs_n && cs && !o_n;
    if (!(rd && !u_n) || ref_vh[a]) chk8({tag, " upper"}, dq[15:8], exp_lane(rd && !u_n, ref_mem[a][15:8]));
    if (!(rd && !l_n) || ref_vl[a]) chk8({tag, " lower"}, dq[7:0],  exp_lane(rd && !l_n, ref_mem[a][7:0]));
    #1 idle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    for (int i = 0; i < (1 << AW); i++) begin
      ref_mem[i] = '0; ref_vh[i] = 1'b0; ref_vl[i] = 1'b0;
    end
    r = $urandom(32'd7);
    idle();
    repeat (3) @(negedge clk);
    chk8("R5 reset upper floats", dq[15:8], 8'hff);
    chk8("R5 reset lower floats", dq[7:0], 8'hff);
    rst_n = 1'b1;

    // R1: full word, oe_n low during write is ignored
    do_write(8'h10, 16'h1234, 0, 0, 0, 0, 1, WP, 0);
    do_read("R1 word write oe low", 8'h10, 0, 0, 0, 0, 1);
    do_write(8'h11, 16'h5a3c, 0, 0, 1, 0, 1, WP, 0);
    do_read("R1 word write oe high", 8'h11, 0, 0, 0, 0, 1);
    // R2: single lanes
    do_write(8'h10, 16'hab77, 0, 1, 1, 0, 1, WP, 0);
    do_read("R2 upper only write", 8'h10, 0, 0, 0, 0, 1);
    do_write(8'h10, 16'h66cd, 1, 0, 1, 0, 1, WP, 0);
    do_read("R2 lower only write", 8'h10, 0, 0, 0, 0, 1);
    // R3: lane-selective reads
    do_read("R3 upper lane read", 8'h10, 0, 1, 0, 0, 1);
    do_read("R3 lower lane read", 8'h10, 1, 0, 0, 0, 1);
    // R4: selected but quiet
    do_read("R4 oe high floats", 8'h10, 0, 0, 1, 0, 1);
    do_read("R4 no byte enable floats", 8'h10, 1, 1, 0, 0, 1);
    do_write(8'h10, 16'h0101, 1, 1, 1, 0, 1, WP, 0);
    do_read("R4 no-lane write ignored", 8'h10, 0, 0, 0, 0, 1);
    // R5: deselected by either select
    do_read("R5 sel_n high floats", 8'h10, 0, 0, 0, 1, 1);
    do_read("R5 sel low floats", 8'h10, 0, 0, 0, 0, 0);
    do_write(8'h10, 16'h0202, 0, 0, 1, 1, 1, WP, 0);
    do_write(8'h10, 16'h0303, 0, 0, 1, 0, 0, WP, 0);
    do_read("R5 deselected write ignored", 8'h10, 0, 0, 0, 0, 1);
    // R6: release within the same clock period
    @(negedge clk);
    addr = 8'h11; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
    #2 chk8("R6 driven before release", dq[15:8], 8'h5a);
    sel_n = 1'b1;
    #1 chk8("R6 upper released same period", dq[15:8], 8'hff);
    chk8("R6 lower released same period", dq[7:0], 8'hff);
    sel_n = 1'b0; sel = 1'b0;
    #1 chk8("R6 released by sel low", dq[7:0], 8'hff);
    idle();
    // R7: each way of ending a write
    do_write(8'h20, 16'hc0de, 0, 0, 1, 0, 1, WP, 1);
    do_read("R7 end by sel_n", 8'h20, 0, 0, 0, 0, 1);
    do_write(8'h21, 16'hbeef, 0, 0, 1, 0, 1, WP, 2);
    do_read("R7 end by sel", 8'h21, 0, 0, 0, 0, 1);
    do_write(8'h22, 16'hface, 0, 1, 1, 0, 1, WP, 3);
    do_read("R7 end by byte enables", 8'h22, 0, 1, 0, 0, 1);
    // R9: exactly minimum pulse
    do_write(8'h23, 16'h9876, 0, 0, 1, 0, 1, WP, 0);
    do_read("R9 minimum pulse stored", 8'h23, 0, 0, 0, 0, 1);
    // R8: reset during a write discards it and keeps contents
    @(negedge clk);
    addr = 8'h23; sel_n = 1'b0; sel = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
    we_n = 1'b0; tb_dq = 16'h4444; tb_oe = 1'b1;
    repeat (WP) @(negedge clk);
    rst_n = 1'b0;
    #2 we_n = 1'b1; tb_oe = 1'b0;
    repeat (2) @(negedge clk);
    idle(); rst_n = 1'b1;
    do_read("R8 pending write discarded", 8'h23, 0, 0, 0, 0, 1);
    do_read("R8 contents kept", 8'h20, 0, 0, 0, 0, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 0)
        do_write(a, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) != 0),
                 WP + $urandom_range(0, 2), (n % 4));
      else
        do_read("R3 random read", a, 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) != 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule